// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link (chip enable, shift clock, one bidirectional data line) that fronts a 16-entry, 4-bit-wide register file. Every transfer is an 8-clock frame. The first four bits are control bits and the last four are a payload. The control bits either load an internal address register, write the payload to the addressed register, or request a read. A read is answered in the following frame: the block turns the data line around and shifts the addressed nibble out most significant bit first.

All serial inputs are brought into the system clock domain through synchronizers, and edge detection is done there. One parameter selects the clock polarity. By default, input bits are taken on the falling shift-clock edge and output bits change on the rising edge; the alternate setting swaps both edges. The pad driver sits outside the block and is controlled by an output-enable port. The register file sits outside as well: it sees an address bus, a write strobe with data, and returns read data combinationally.

Top module: `serial_reg_port`

## Requirements
- R1: While chip enable is low, the data-line enable is low and the frame bit counter is held at zero, so a partial frame cut short by deselect is discarded. Out of reset the enable and the write strobe are both low.
- R2: A frame is 8 shift clocks, taken in the order: one ignored bit, then read/write (1 = read), then address-load, then data, then payload bits 3, 2, 1, 0. A frame with address-load=1 and data=0 copies the payload into the address register, which drives regAddr.
- R3: A frame with address-load=0, or with address-load=1 and data=1, leaves the address register unchanged.
- R4: A frame with data=1 and read/write=0 and address-load=0 gives exactly one system-clock pulse of regWrEn, with regWrData equal to the payload and regAddr equal to the current address register.
- R5: No other control combination gives a write. This includes data=1 with read/write or address-load set, and the all-zero frame.
- R6: After a frame with read/write=1, address-load=1 and data=0, the next frame turns the line around as follows. The enable rises at the output edge of clock 2. Bits 3..0 of the addressed register appear at the output edges of clocks 5..8. The enable falls at the output edge of clock 1 of the frame after that.
- R7: The bits sampled during a frame that is serving a read are discarded. They cause no address load, no write and no new read.
- R8: The address register keeps its value across chip-enable low periods.
- R9: Frames may follow back to back under one chip-enable high period, so a read may be followed directly by a write.
- R10: With the polarity parameter set to the alternate value, the behaviour is the same, with inputs taken on rising shift-clock edges and outputs changing on falling edges.
- R11: Deselecting between a read request and its serving frame cancels the read; no data is driven afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipEn | input | 1 | Serial chip enable, active high |
| shiftClk | input | 1 | Serial shift clock |
| sdIn | input | 1 | Data line as seen at the pad input |
| sdOut | output | 1 | Data to drive onto the line |
| sdOe | output | 1 | Pad output enable for the data line |
| regAddr | output | 4 | Address register contents to the register file |
| regWrData | output | 4 | Write data to the register file |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 4 | Read data from the register file at regAddr |

## Verification
The bench goes after the turnaround points.

- An off-by-one in the output-edge count would raise the enable at clock 1 or 3, or shift the nibble by one clock. The per-clock enable and data checks catch this.
- A design that keeps decoding while it serves a read would turn the dummy write frame sent during the serve into a real write. It would also turn a read request sent during the serve into a spurious second turnaround.
- A design that resets the address on deselect would send the write after reselect to address zero.
- A design that keeps its bit counter through deselect would misalign every later frame.
- A design that keeps its pending read through deselect would drive the line in the first frame after reselect.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int NIB_W      = 4;
  localparam int CTL_W      = 4;
  localparam int FRAME_BITS = CTL_W + NIB_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int HOLD_W     = FRAME_BITS - 2;

  typedef struct packed {
    logic clrAll;
    logic sample;
    logic loadAddr;
    logic doWrite;
    logic oeOn;
    logic oeOff;
    logic loadOut;
    logic shiftOut;
  } srpStrobe_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceLive,
  input  logic             sampleEdge,
  input  logic             outEdge,
  input  logic [2:0]       ctlBits,
  output srpStrobe_t       strb,
  output logic [CNT_W-1:0] bitCnt,
  output logic             serving
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] OE_POINT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] OUT_FIRST = CNT_W'(CTL_W);

  logic pending;
  logic frameEnd;
  logic isRw, isAd, isDt;

  assign isRw = ctlBits[2];
  assign isAd = ctlBits[1];
  assign isDt = ctlBits[0];
  assign frameEnd = sampleEdge && (bitCnt == LAST_BIT) && !serving;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      pending <= 1'b0;
      serving <= 1'b0;
    end else if (!ceLive) begin
      bitCnt  <= '0;
      pending <= 1'b0;
      serving <= 1'b0;
    end else begin
      if (sampleEdge)
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      if (frameEnd && isRw && isAd && !isDt)
        pending <= 1'b1;
      if (outEdge && bitCnt == '0) begin
        serving <= pending;
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.clrAll   = !ceLive;
    strb.sample   = sampleEdge;
    strb.loadAddr = frameEnd && isAd && !isDt;
    strb.doWrite  = frameEnd && isDt && !isRw && !isAd;
    strb.oeOff    = outEdge && (bitCnt == '0);
    strb.oeOn     = outEdge && (bitCnt == OE_POINT) && serving;
    strb.loadOut  = outEdge && (bitCnt == OUT_FIRST) && serving;
    strb.shiftOut = outEdge && (bitCnt > OUT_FIRST) && serving;
  end
endmodule

// File: rtl/srp_dpath.sv
module srp_dpath
  import srp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  srpStrobe_t       strb,
  input  logic             sdBit,
  input  logic [NIB_W-1:0] rdData,
  output logic [2:0]       ctlBits,
  output logic [NIB_W-1:0] addr,
  output logic [NIB_W-1:0] wrData,
  output logic             wrEn,
  output logic             sdOut,
  output logic             sdOe
);
  logic [HOLD_W-1:0] holdReg;
  logic [NIB_W-1:0]  outShift;
  logic [NIB_W-1:0]  payload;
  logic              oeReg;

  assign ctlBits = holdReg[HOLD_W-1 -: 3];
  assign payload = {holdReg[NIB_W-2:0], sdBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (strb.loadAddr) addr <= payload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      outShift <= '0;
      oeReg    <= 1'b0;
      wrEn     <= 1'b0;
      wrData   <= '0;
    end else if (strb.clrAll) begin
      holdReg  <= '0;
      outShift <= '0;
      oeReg    <= 1'b0;
      wrEn     <= 1'b0;
    end else begin
      wrEn <= strb.doWrite;
      if (strb.doWrite) wrData <= payload;
      if (strb.sample)  holdReg <= {holdReg[HOLD_W-2:0], sdBit};
      if (strb.oeOff)     oeReg <= 1'b0;
      else if (strb.oeOn) oeReg <= 1'b1;
      if (strb.oeOn)          outShift <= '0;
      else if (strb.loadOut)  outShift <= rdData;
      else if (strb.shiftOut) outShift <= {outShift[NIB_W-2:0], 1'b0};
    end
  end

  assign sdOe  = oeReg;
  assign sdOut = oeReg & outShift[NIB_W-1];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter bit SAMPLE_ON_FALL = 1'b1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             shiftClk,
  input  logic             sdIn,
  output logic             sdOut,
  output logic             sdOe,
  output logic [NIB_W-1:0] regAddr,
  output logic [NIB_W-1:0] regWrData,
  output logic             regWrEn,
  input  logic [NIB_W-1:0] regRdData
);
  logic             sclkNorm;
  logic             ceLive, sclkS, sdS, sclkD;
  logic             sampleEdge, outEdge;
  logic [2:0]       ctlBits;
  logic [CNT_W-1:0] bitCnt;
  logic             serving;
  srpStrobe_t       strb;

  if (SAMPLE_ON_FALL) begin : g_pol_fall
    assign sclkNorm = shiftClk;
  end else begin : g_pol_rise
    assign sclkNorm = ~shiftClk;
  end

  srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({chipEn, sclkNorm, sdIn}),
    .dout({ceLive, sclkS, sdS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkD <= 1'b0;
    else       sclkD <= sclkS;
  end

  assign sampleEdge = ceLive & sclkD & ~sclkS;
  assign outEdge    = ceLive & ~sclkD & sclkS;

  srp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceLive    (ceLive),
    .sampleEdge(sampleEdge),
    .outEdge   (outEdge),
    .ctlBits   (ctlBits),
    .strb      (strb),
    .bitCnt    (bitCnt),
    .serving   (serving)
  );

  srp_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdBit  (sdS),
    .rdData (regRdData),
    .ctlBits(ctlBits),
    .addr   (regAddr),
    .wrData (regWrData),
    .wrEn   (regWrEn),
    .sdOut  (sdOut),
    .sdOe   (sdOe)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             ceLive,
  input logic             sdOe,
  input logic             regWrEn,
  input logic [CNT_W-1:0] bitCnt,
  input logic             serving
);
  assert_release_on_deselect_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ceLive |=> !sdOe);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ceLive && $past(ceLive) && bitCnt != $past(bitCnt)) |->
      bitCnt == CNT_W'($past(bitCnt) + 1'b1));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_oe_rise_point_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> bitCnt == CNT_W'(1));

  assert_oe_only_serving_R6: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> serving);

  assert_no_write_in_serve_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !$past(serving));
endmodule

bind serial_reg_port srp_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .ceLive (ceLive),
  .sdOe   (sdOe),
  .regWrEn(regWrEn),
  .bitCnt (bitCnt),
  .serving(serving)
);

// File: tb/serial_reg_port_tb.sv
`timescale 1ns/1ps
module serial_reg_port_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0;
  logic lvl = 1'b0;
  logic sdIn = 1'b0;
  logic sclkB;
  logic sdOutA, sdOeA, wrEnA, sdOutB, sdOeB, wrEnB;
  logic [3:0] addrA, wdA, rdA, addrB, wdB, rdB;
  logic [3:0] memA [16];
  logic [3:0] memB [16];
  logic [3:0] memM [16];
  logic [3:0] addrM = '0;
  bit servM = 0, pendM = 0;
  int checks = 0, bad = 0;
  int wrCntA = 0, wrCntB = 0;
  logic [7:0] lastA, lastB;

  always #10 clk = ~clk;
  assign sclkB = ~lvl;
  assign rdA = memA[addrA];
  assign rdB = memB[addrB];

  serial_reg_port u_dut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .shiftClk(lvl), .sdIn(sdIn),
    .sdOut(sdOutA), .sdOe(sdOeA), .regAddr(addrA), .regWrData(wdA),
    .regWrEn(wrEnA), .regRdData(rdA));

  serial_reg_port #(.SAMPLE_ON_FALL(1'b0)) u_alt (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .shiftClk(sclkB), .sdIn(sdIn),
    .sdOut(sdOutB), .sdOe(sdOeB), .regAddr(addrB), .regWrData(wdB),
    .regWrEn(wrEnB), .regRdData(rdB));

  initial begin
    for (int i = 0; i < 16; i++) begin
      memA[i] = '0; memB[i] = '0; memM[i] = '0;
    end
  end

  always @(posedge clk) begin
    if (wrEnA) begin memA[addrA] <= wdA; wrCntA <= wrCntA + 1; lastA <= {addrA, wdA}; end
    if (wrEnB) begin memB[addrB] <= wdB; wrCntB <= wrCntB + 1; lastB <= {addrB, wdB}; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frame(input bit rw, input bit ad, input bit dt, input logic [3:0] pay,
                       input string tag);
    logic [7:0] bits;
    bit expOe, expBit, expWr;
    logic [7:0] expRec;
    bits = {1'b1, rw, ad, dt, pay};
    wrCntA = 0; wrCntB = 0;
    for (int n = 1; n <= 8; n++) begin
      sdIn = bits[8-n];
      repeat (H) @(posedge clk);
      lvl = 1'b1;
      if (n == 1) begin servM = pendM; pendM = 0; end
      repeat (H-1) @(posedge clk);
      @(negedge clk);
      expOe = servM && n >= 2;
      chk(sdOeA == expOe, {tag, " R6 enable"}, sdOeA, expOe);
      chk(sdOeB == expOe, {tag, " R10 enable alt"}, sdOeB, expOe);
      if (expOe && n >= 5) begin
        expBit = memM[addrM][8-n];
        chk(sdOutA == expBit, {tag, " R6 data bit"}, sdOutA, expBit);
        chk(sdOutB == expBit, {tag, " R10 data bit alt"}, sdOutB, expBit);
      end
      lvl = 1'b0;
      repeat (H) @(posedge clk);
    end
    expWr = 0;
    if (!servM) begin
      if (ad && !dt) addrM = pay;
      if (dt && !rw && !ad) begin expWr = 1; memM[addrM] = pay; end
      if (rw && ad && !dt) pendM = 1;
    end
    expRec = {addrM, pay};
    @(negedge clk);
    chk(wrCntA == int'(expWr), {tag, " R4/R5 write count"}, wrCntA, int'(expWr));
    chk(wrCntB == int'(expWr), {tag, " R10 write count alt"}, wrCntB, int'(expWr));
    if (expWr) begin
      chk(lastA == expRec, {tag, " R4 write addr/data"}, lastA, expRec);
      chk(lastB == expRec, {tag, " R10 write addr/data alt"}, lastB, expRec);
    end
    chk(addrA == addrM, {tag, " R2/R3 address"}, addrA, addrM);
    chk(addrB == addrM, {tag, " R10 address alt"}, addrB, addrM);
  endtask

  task automatic deselect();
    chipEn = 1'b0;
    repeat (H) @(posedge clk);
    @(negedge clk);
    chk(sdOeA == 1'b0, "R1 deselect enable", sdOeA, 0);
    chk(sdOeB == 1'b0, "R1 deselect enable alt", sdOeB, 0);
    servM = 0; pendM = 0;
    chipEn = 1'b1;
    repeat (H) @(posedge clk);
  endtask

  task automatic partial(input int k);
    for (int n = 0; n < k; n++) begin
      sdIn = 1'b1;
      repeat (H) @(posedge clk); lvl = 1'b1;
      repeat (H) @(posedge clk); lvl = 1'b0;
      repeat (H) @(posedge clk);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sdOeA == 0 && sdOeB == 0, "R1 reset enable", sdOeA, 0);
    chk(wrEnA == 0 && wrEnB == 0, "R1 reset strobe", wrEnA, 0);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    chipEn = 1'b1;
    repeat (H) @(posedge clk);

    frame(0, 1, 0, 4'h5, "R2 load");
    frame(0, 0, 1, 4'h9, "R4 write");
    frame(1, 1, 0, 4'h5, "R6 request");
    frame(0, 0, 1, 4'h6, "R7 served dummy write");
    frame(0, 0, 0, 4'h0, "R5 zero frame release");

    frame(0, 1, 0, 4'h3, "R2 load3");
    frame(0, 0, 1, 4'hC, "R4 writeC");
    frame(1, 1, 0, 4'h3, "R9 request");
    frame(0, 0, 0, 4'h0, "R9 served");
    frame(0, 0, 1, 4'h7, "R9 write after read");
    frame(1, 1, 0, 4'h3, "R7 request");
    frame(1, 1, 0, 4'h5, "R7 served read req");
    frame(0, 0, 0, 4'h0, "R7 no second serve");

    frame(1, 0, 0, 4'hF, "R3 rw only");
    frame(0, 1, 1, 4'hA, "R3/R5 ad and dt");
    frame(1, 0, 1, 4'h2, "R5 rw and dt");
    frame(0, 0, 1, 4'h4, "R3 write old addr");

    deselect();
    frame(0, 0, 1, 4'hB, "R8 write after reselect");
    frame(1, 1, 0, 4'h3, "R8 request");
    frame(0, 0, 0, 4'h0, "R8 served");

    partial(3);
    deselect();
    frame(0, 1, 0, 4'h8, "R1 after partial");
    frame(0, 0, 1, 4'h1, "R1 write after partial");

    frame(1, 1, 0, 4'h8, "R11 request");
    deselect();
    frame(0, 0, 0, 4'h0, "R11 cancelled");

    summary();
    $finish;
  end
endmodule